// File: doc/BRIEF.md
# Quad-Channel DAC Serial Register Front End

This block is the digital side of a four-channel, 8-bit digital-to-analog converter. A host sends 12-bit commands over a three-wire serial link: an active-low select, a serial clock and a data line. The link uses clock polarity 0 and phase 0. The block samples these pins with its own system clock. It assembles each command in a shift register and decodes it once select is released. The command then loads an input register, all of the input registers, the DAC registers, or a mix of these.

Each channel holds two registers: a staged input value and the DAC value that drives the parallel output. An active-low load strobe copies every staged value into its DAC register, with no serial clock involved. An active-low clear zeroes every staged and DAC register at once, without waiting for a clock edge. A serial output repeats the shift register's top bit. A host can use it to read back the previous command or to feed a second device.

Top module: `qdac_frontend`

## Requirements
- R1: After power-on reset, every DAC output byte is 0x00 and the serial output is 0.
- R2: A command is 12 bits, sent MSB first and captured on rising serial-clock edges while select is low: bits [11:10] are the opcode, bits [9:8] the channel, and bits [7:0] the data. Serial-clock edges while select is high change nothing.
- R3: Opcode 01 writes the data into the selected channel's input register and leaves every DAC output unchanged.
- R4: Opcode 10 writes the data into the selected channel's input register, then copies all four input registers, including the new value, into the DAC registers.
- R5: Opcode 11 with channel bit 8 = 0 copies all four input registers into the DAC registers.
- R6: Opcode 11 with channel bit 8 = 1 writes the data into all four input registers and all four DAC registers.
- R7: Opcode 00 changes no register.
- R8: If select rises after any number of captured bits other than 12, the command is discarded, no register changes, and the next 12-bit command is decoded normally.
- R9: While the load strobe is low, each DAC register takes its input register's value, with the serial clock idle.
- R10: Driving clear low zeroes all input and DAC registers at once, with no clock edge needed.
- R11: If the load strobe is low when select rises, the DAC registers end up holding the input values that command has just written.
- R12: The serial output takes the shift register's MSB on each falling serial-clock edge while select is low. At every rising edge it therefore shows the bit captured 12 edges earlier, or 0 if there has been no such edge since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, must run several times faster than the serial clock |
| rst_n | input | 1 | Active-low power-on reset |
| cs_n | input | 1 | Active-low serial select |
| sclk | input | 1 | Serial clock, idles low |
| din | input | 1 | Serial data in |
| load_n | input | 1 | Active-low load strobe, level sensitive |
| clr_n | input | 1 | Active-low asynchronous clear |
| dout | output | 1 | Serial data out, for readback and chaining |
| dac_out | output | CHANNELS*DATA_W | DAC register values, channel i at bits [i*DATA_W +: DATA_W] |

## Verification
A bit counter that drifts by one slot shows up in two ways. A correct 12-bit command gets dropped, and the readback stream on the serial output lags or leads by one bit. Both are visible in the same frame, a few system clocks after select rises. A wrong input register stays hidden until the next update command or load strobe copies it to the outputs. For that reason the bench follows every group of loads with a copy into the DAC registers. A wrong DAC register shows on the parallel output two synchronizer stages plus two register stages after the select rise. A clear that is not asynchronous shows before the next clock edge.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

   localparam int OP_W = 2;

   typedef enum logic [OP_W-1:0] {
      OP_NOP      = 2'b00,
      OP_LOAD     = 2'b01,
      OP_LOAD_UPD = 2'b10,
      OP_GLOBAL   = 2'b11
   } op_e;

endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
   parameter int              W       = 4,
   parameter int              STAGES  = 2,
   parameter logic [W-1:0]    RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("qdac_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] pipe_q [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pipe_q[s] <= RST_VAL;
            end else begin
               if (s == 0) pipe_q[s] <= d_i;
               else        pipe_q[s] <= pipe_q[(s == 0) ? 0 : s-1];
            end
         end
      end
   endgenerate

   assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/qdac_shift.sv
module qdac_shift #(
   parameter int WORD_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_s,
   input  logic              cs_s,
   input  logic              din_s,
   output logic [WORD_W-1:0] word_o,
   output logic              valid_o,
   output logic              dout_o
);

   localparam int CNT_MAX = WORD_W + 1;
   localparam int CNT_W   = $clog2(CNT_MAX + 1);

   generate
      if (WORD_W < 4) begin : g_bad_word
         $error("qdac_shift: WORD_W too small");
      end
   endgenerate

   logic              sclk_d, cs_d;
   logic              sclk_rise, sclk_fall, cs_rise;
   logic [WORD_W-1:0] sr_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              dout_q;

   assign sclk_rise = sclk_s & ~sclk_d;
   assign sclk_fall = ~sclk_s & sclk_d;
   assign cs_rise   = cs_s & ~cs_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d  <= 1'b0;
         cs_d    <= 1'b1;
         sr_q    <= '0;
         cnt_q   <= '0;
         valid_o <= 1'b0;
         dout_q  <= 1'b0;
      end else begin
         sclk_d  <= sclk_s;
         cs_d    <= cs_s;
         valid_o <= cs_rise && (cnt_q == CNT_W'(WORD_W));
         if (sclk_rise && !cs_s) begin
            sr_q <= {sr_q[WORD_W-2:0], din_s};
            if (cnt_q != CNT_W'(CNT_MAX)) cnt_q <= cnt_q + 1'b1;
         end
         if (cs_rise) cnt_q <= '0;
         if (sclk_fall && !cs_s) dout_q <= sr_q[WORD_W-1];
      end
   end

   assign word_o = sr_q;
   assign dout_o = dout_q;

   // R2: nothing is captured while deselected
   a_r2_hold_deselected: assert property (@(posedge clk) disable iff (!rst_n)
      cs_s |=> $stable(sr_q));
   // R2: a decoded word is only ever presented after select has gone high
   a_r2_valid_after_release: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> cs_s);
   // R8: every release restarts the bit count
   a_r8_count_restart: assert property (@(posedge clk) disable iff (!rst_n)
      cs_rise |=> (cnt_q == '0));
   // R12: the serial output only moves after a falling serial edge
   a_r12_dout_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(dout_q) |-> $past(sclk_fall));

endmodule

// File: rtl/qdac_regs.sv
module qdac_regs
   import qdac_pkg::*;
#(
   parameter int CHANNELS = 4,
   parameter int DATA_W   = 8,
   parameter int WORD_W   = 12
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clr_n,
   input  logic                       valid_i,
   input  logic [WORD_W-1:0]          word_i,
   input  logic                       load_s,
   output logic [CHANNELS*DATA_W-1:0] dac_o
);

   localparam int CH_W = $clog2(CHANNELS);

   generate
      if (CHANNELS < 2 || (1 << CH_W) != CHANNELS) begin : g_bad_channels
         $error("qdac_regs: CHANNELS must be a power of two, at least 2");
      end
      if (WORD_W != OP_W + CH_W + DATA_W) begin : g_bad_word
         $error("qdac_regs: WORD_W does not match opcode, channel and data fields");
      end
   endgenerate

   logic              bank_rst_n;
   op_e               op;
   logic [CH_W-1:0]   ch;
   logic [DATA_W-1:0] data;
   logic              global_all, upd_all;

   assign bank_rst_n = rst_n & clr_n;
   assign op         = op_e'(word_i[WORD_W-1 -: OP_W]);
   assign ch         = word_i[DATA_W +: CH_W];
   assign data       = word_i[DATA_W-1:0];
   assign global_all = valid_i && (op == OP_GLOBAL) && ch[0];
   assign upd_all    = valid_i && ((op == OP_LOAD_UPD) || ((op == OP_GLOBAL) && !ch[0]));

   logic [DATA_W-1:0] in_q  [CHANNELS];
   logic [DATA_W-1:0] dac_q [CHANNELS];
   logic [DATA_W-1:0] in_nx [CHANNELS];

   generate
      for (genvar i = 0; i < CHANNELS; i++) begin : g_chan
         logic wr_one;
         assign wr_one = valid_i && ((op == OP_LOAD) || (op == OP_LOAD_UPD))
                         && (ch == CH_W'(i));

         always_comb begin
            in_nx[i] = in_q[i];
            if (wr_one || global_all) in_nx[i] = data;
         end

         always_ff @(posedge clk or negedge bank_rst_n) begin
            if (!bank_rst_n) begin
               in_q[i]  <= '0;
               dac_q[i] <= '0;
            end else begin
               in_q[i] <= in_nx[i];
               if (global_all || upd_all || !load_s) dac_q[i] <= in_nx[i];
            end
         end

         assign dac_o[i*DATA_W +: DATA_W] = dac_q[i];

         // R3: a single input load leaves the DAC register alone
         a_r3_load_keeps_dac: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
            (valid_i && op == OP_LOAD && load_s) |=> $stable(dac_q[i]));
         // R6: the broadcast load reaches both levels
         a_r6_broadcast: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
            global_all |=> (dac_q[i] == $past(data)) && (in_q[i] == $past(data)));
         // R7: a no-op touches nothing
         a_r7_nop_holds: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
            (valid_i && op == OP_NOP && load_s) |=> $stable(in_q[i]) && $stable(dac_q[i]));
         // R9: a low strobe copies the staged value
         a_r9_strobe_copy: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
            (!load_s && !valid_i) |=> (dac_q[i] == $past(in_q[i])));
         // R10: clear holds both levels at zero
         a_r10_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
            !clr_n |-> (in_q[i] == '0) && (dac_q[i] == '0));
      end
   endgenerate

endmodule

// File: rtl/qdac_frontend.sv
module qdac_frontend
   import qdac_pkg::*;
#(
   parameter int CHANNELS    = 4,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cs_n,
   input  logic                       sclk,
   input  logic                       din,
   input  logic                       load_n,
   input  logic                       clr_n,
   output logic                       dout,
   output logic [CHANNELS*DATA_W-1:0] dac_out
);

   localparam int CH_W   = $clog2(CHANNELS);
   localparam int WORD_W = OP_W + CH_W + DATA_W;

   logic [3:0]        pins_s;
   logic              load_s, cs_s, sclk_s, din_s;
   logic [WORD_W-1:0] word;
   logic              word_valid;

   qdac_sync #(
      .W       (4),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (4'b1100)
   ) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({load_n, cs_n, sclk, din}),
      .q_o   (pins_s)
   );

   assign {load_s, cs_s, sclk_s, din_s} = pins_s;

   qdac_shift #(
      .WORD_W (WORD_W)
   ) i_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .sclk_s  (sclk_s),
      .cs_s    (cs_s),
      .din_s   (din_s),
      .word_o  (word),
      .valid_o (word_valid),
      .dout_o  (dout)
   );

   qdac_regs #(
      .CHANNELS (CHANNELS),
      .DATA_W   (DATA_W),
      .WORD_W   (WORD_W)
   ) i_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_n   (clr_n),
      .valid_i (word_valid),
      .word_i  (word),
      .load_s  (load_s),
      .dac_o   (dac_out)
   );

endmodule

// File: tb/test_qdac_frontend.sv
module test_qdac_frontend;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1;
   logic        sclk = 1'b0;
   logic        din = 1'b0;
   logic        load_n = 1'b1;
   logic        clr_n = 1'b1;
   logic        dout;
   logic [31:0] dac_out;

   always #5 clk = ~clk;

   qdac_frontend i_qdac_frontend (
      .clk     (clk),
      .rst_n   (rst_n),
      .cs_n    (cs_n),
      .sclk    (sclk),
      .din     (din),
      .load_n  (load_n),
      .clr_n   (clr_n),
      .dout    (dout),
      .dac_out (dac_out)
   );

   int          checks = 0;
   int          errors = 0;
   bit          finished = 0;
   logic [7:0]  m_in  [4];
   logic [7:0]  m_dac [4];
   logic [11:0] m_sr = '0;
   bit          m_load = 0;

   function automatic logic [31:0] exp_flat();
      return {m_dac[3], m_dac[2], m_dac[1], m_dac[0]};
   endfunction

   function automatic string tag_of(int op, int ch);
      case (op)
         0:       return "R7";
         1:       return "R3";
         2:       return "R4";
         default: return ch[0] ? "R6" : "R5";
      endcase
   endfunction

   task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wait_clk(int n);
      repeat (n) @(negedge clk);
   endtask

   // Sends nbits bits of w, MSB first, and compares dout against the
   // model shift register at each rising serial edge (R12).
   task automatic send(logic [15:0] w, int nbits, output int bad);
      bad = 0;
      cs_n = 1'b0;
      wait_clk(4);
      for (int b = 0; b < nbits; b++) begin
         din = w[nbits-1-b];
         wait_clk(4);
         if (dout !== m_sr[11]) bad++;
         m_sr = {m_sr[10:0], w[nbits-1-b]};
         sclk = 1'b1;
         wait_clk(4);
         sclk = 1'b0;
         wait_clk(4);
      end
      cs_n = 1'b1;
      din = 1'b0;
      wait_clk(10);
   endtask

   task automatic apply(logic [11:0] w);
      logic [1:0] op;
      logic [1:0] ch;
      logic [7:0] d;
      op = w[11:10];
      ch = w[9:8];
      d  = w[7:0];
      case (op)
         2'b01: m_in[ch] = d;
         2'b10: begin
            m_in[ch] = d;
            for (int i = 0; i < 4; i++) m_dac[i] = m_in[i];
         end
         2'b11: begin
            if (ch[0]) begin
               for (int i = 0; i < 4; i++) begin
                  m_in[i]  = d;
                  m_dac[i] = d;
               end
            end else begin
               for (int i = 0; i < 4; i++) m_dac[i] = m_in[i];
            end
         end
         default: ;
      endcase
      if (m_load) for (int i = 0; i < 4; i++) m_dac[i] = m_in[i];
   endtask

   task automatic frame(logic [11:0] w, string tag);
      int bad;
      send({4'h0, w}, 12, bad);
      check(bad == 0, "R12", bad, 0);
      apply(w);
      check(dac_out === exp_flat(), tag, dac_out, exp_flat());
   endtask

   initial begin
      #(200000 * 10);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int bad;
      for (int i = 0; i < 4; i++) begin
         m_in[i]  = '0;
         m_dac[i] = '0;
      end
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(5);

      // R1: reset state
      check(dac_out === 32'h0, "R1", dac_out, 32'h0);
      check(dout === 1'b0, "R1", {31'h0, dout}, 32'h0);

      // R2..R7: sweep every opcode and channel with computed data bytes
      for (int op = 0; op < 4; op++) begin
         for (int ch = 0; ch < 4; ch++) begin
            for (int k = 0; k < 2; k++) begin
               logic [7:0] d;
               d = 8'((op * 16 + ch * 4 + k) * 37 + 5);
               frame({op[1:0], ch[1:0], d}, tag_of(op, ch));
            end
         end
      end

      // R2: serial clock pulses while deselected are ignored
      for (int p = 0; p < 5; p++) begin
         din = 1'b1;
         sclk = 1'b1;
         wait_clk(4);
         sclk = 1'b0;
         wait_clk(4);
      end
      din = 1'b0;
      wait_clk(4);
      frame(12'h53C, "R2");
      frame(12'hC00, "R2");

      // R8: short and long frames are discarded, then a full frame works
      send({5'h0, 11'h6D5}, 11, bad);
      check(dac_out === exp_flat(), "R8", dac_out, exp_flat());
      send({3'h0, 13'h1B54}, 13, bad);
      check(dac_out === exp_flat(), "R8", dac_out, exp_flat());
      frame(12'hC00, "R8");
      frame(12'hD77, "R8");

      // R9: staged writes, then the strobe copies them
      frame(12'h411, "R3");
      frame(12'h799, "R3");
      load_n = 1'b0;
      wait_clk(10);
      for (int i = 0; i < 4; i++) m_dac[i] = m_in[i];
      check(dac_out === exp_flat(), "R9", dac_out, exp_flat());
      load_n = 1'b1;
      wait_clk(5);

      // R11: strobe held low across the select release
      load_n = 1'b0;
      m_load = 1;
      frame(12'h6E4, "R11");
      frame(12'h542, "R11");
      load_n = 1'b1;
      m_load = 0;
      wait_clk(5);

      // R10: asynchronous clear, visible before any clock edge
      frame(12'hD5A, "R6");
      @(negedge clk);
      clr_n = 1'b0;
      #2;
      check(dac_out === 32'h0, "R10", dac_out, 32'h0);
      wait_clk(3);
      clr_n = 1'b1;
      wait_clk(3);
      for (int i = 0; i < 4; i++) begin
         m_in[i]  = '0;
         m_dac[i] = '0;
      end
      frame(12'hC00, "R10");

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule